// File: doc/BRIEF.md
# Floppy Data-Rate and Power Control Register

This block is a write-only control register in the host interface of a floppy disk controller. One host write sets four things: a two-bit transfer-rate code, a three-bit write-precompensation code, a request to enter manual low-power mode, and a software reset that clears itself.

The rate code the drive logic actually uses is shared with a second configuration register that lives elsewhere. That register reports its own rate writes through a strobe and a two-bit value. The block keeps a single effective rate, which is whatever the most recent writer supplied.

Manual low-power mode ends on its own when the host touches the data register or the main status register. It also ends on a software reset. The clock gating and the data separator are driven from the outputs and are not part of this block.

Top module: `fdc_rate_ctl`

## Requirements
- R1: After hardware reset the outputs are rate_code = 2 (250 kbps), pcomp_code = 0 (default precompensation), low_pwr = 0 and soft_rst = 0. This corresponds to a stored byte of 0x02.
- R2: A host write (wr_en with sel_ctl) loads wdata[1:0] into rate_code, visible from the next cycle.
- R3: An alt_wr strobe loads alt_rate into rate_code from the next cycle, so the effective rate always comes from whichever register was written last.
- R4: When alt_wr and a host write fall in the same cycle, rate_code takes alt_rate.
- R5: A host write loads wdata[4:2] into pcomp_code. An alt_wr strobe leaves pcomp_code unchanged.
- R6: A host write with wdata[7] = 1 makes soft_rst high for exactly the following cycle, after which it returns to 0.
- R7: The software reset leaves rate_code and pcomp_code at the values written, not at the reset defaults.
- R8: A host write with wdata[6] = 1 and wdata[7] = 0 makes low_pwr high from the next cycle, and it stays high while no exit event occurs.
- R9: low_pwr drops in the same cycle that data_acc or stat_acc is high, and it stays low afterwards.
- R10: A host write with wdata[7] = 1 ends low-power mode, even when wdata[6] is also 1.
- R11: None of the following changes any output: a host read (rd_en with sel_ctl), a write strobe without sel_ctl, or the value of wdata[5].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| sel_ctl | input | 1 | Address decode hit for this register |
| wdata | input | 8 | Host write data |
| alt_wr | input | 1 | Rate write to the other configuration register |
| alt_rate | input | 2 | Rate field of that write |
| data_acc | input | 1 | Access to the data register |
| stat_acc | input | 1 | Access to the main status register |
| rate_code | output | 2 | Effective data-rate code |
| pcomp_code | output | 3 | Write-precompensation code |
| low_pwr | output | 1 | Manual low-power mode active |
| soft_rst | output | 1 | One-cycle software reset pulse |

## Verification
Two pairs of events can land in the same cycle. A host rate write can coincide with an alt_wr strobe, and a low-power entry or software reset can coincide with a data or status access. The bench drives each pair together on a single clock. It compares the rate against the value from the configuration strobe, and the low-power flag against the rule that the access gates it at once while a write sets it for the next cycle. Expected values come from a small model built from the requirements, queued by the driver and compared by a separate monitor shortly before each rising edge.

// File: rtl/fdc_rate_ctl.sv
module fdc_rate_ctl #(
  parameter int RATE_W = 2,
  parameter int PC_W   = 3,
  parameter logic [RATE_W-1:0] RATE_RST = 2'd2,
  parameter logic [PC_W-1:0]   PC_RST   = 3'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              sel_ctl,
  input  logic [7:0]        wdata,
  input  logic              alt_wr,
  input  logic [RATE_W-1:0] alt_rate,
  input  logic              data_acc,
  input  logic              stat_acc,
  output logic [RATE_W-1:0] rate_code,
  output logic [PC_W-1:0]   pcomp_code,
  output logic              low_pwr,
  output logic              soft_rst
);

  localparam int PC_LSB = RATE_W;

  logic [RATE_W-1:0] rate_q;
  logic [PC_W-1:0]   pc_q;
  logic              lp_q, srst_q;
  logic              own_wr, rst_bit, lp_bit, rsv_bit, wake;

  assign own_wr  = wr_en & sel_ctl;
  assign rst_bit = wdata[7];
  assign lp_bit  = wdata[6];
  assign rsv_bit = wdata[5];
  assign wake    = data_acc | stat_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= RATE_RST;
      pc_q   <= PC_RST;
      lp_q   <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (alt_wr)      rate_q <= alt_rate;
      else if (own_wr) rate_q <= wdata[RATE_W-1:0];
      if (own_wr) pc_q <= wdata[PC_LSB +: PC_W];
      srst_q <= own_wr & rst_bit;
      if (own_wr && rst_bit)     lp_q <= 1'b0;
      else if (own_wr && lp_bit) lp_q <= 1'b1;
      else if (wake)             lp_q <= 1'b0;
    end
  end

  assign rate_code  = rate_q;
  assign pcomp_code = pc_q;
  assign low_pwr    = lp_q & ~wake;
  assign soft_rst   = srst_q;

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    own_wr && rst_bit |=> soft_rst);
  p_alt_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alt_wr |=> rate_code == $past(alt_rate));
  p_wake_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> !low_pwr);
  p_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    own_wr && lp_bit && !rst_bit |=> low_pwr || wake);
  p_reset_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    own_wr && rst_bit |=> !low_pwr);
  p_read_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !own_wr && !alt_wr && (rd_en || rsv_bit) |=> $stable({rate_code, pcomp_code}));

endmodule

// File: tb/fdc_rate_ctl_tb.sv
module fdc_rate_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, sel_ctl = 0, alt_wr = 0, data_acc = 0, stat_acc = 0;
  logic [7:0] wdata = 0;
  logic [1:0] alt_rate = 0;
  logic [1:0] rate_code;
  logic [2:0] pcomp_code;
  logic low_pwr, soft_rst;

  always #4 clk = ~clk;

  fdc_rate_ctl u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .sel_ctl(sel_ctl), .wdata(wdata), .alt_wr(alt_wr), .alt_rate(alt_rate),
    .data_acc(data_acc), .stat_acc(stat_acc), .rate_code(rate_code),
    .pcomp_code(pcomp_code), .low_pwr(low_pwr), .soft_rst(soft_rst));

  typedef struct { logic [1:0] r; logic [2:0] p; logic lp; logic sr; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [1:0] m_r = 2; logic [2:0] m_p = 0; logic m_lp = 0, m_sr = 0;

  task automatic cyc(input logic w, input logic rd, input logic s, input logic [7:0] d,
                     input logic aw, input logic [1:0] ar, input logic da, input logic sa,
                     input string tag);
    exp_t e;
    logic ow;
    @(negedge clk);
    wr_en = w; rd_en = rd; sel_ctl = s; wdata = d;
    alt_wr = aw; alt_rate = ar; data_acc = da; stat_acc = sa;
    e.r = m_r; e.p = m_p; e.lp = m_lp & ~(da | sa); e.sr = m_sr; e.tag = tag;
    q.push_back(e);
    ow = w & s;
    if (aw) m_r = ar; else if (ow) m_r = d[1:0];
    if (ow) m_p = d[4:2];
    m_sr = ow & d[7];
    if (ow && d[7]) m_lp = 0;
    else if (ow && d[6]) m_lp = 1;
    else if (da | sa) m_lp = 0;
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 8'h00, 0, 2'd0, 0, 0, tag);
  endtask

  initial forever begin
    exp_t e;
    @(negedge clk); #3;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (rate_code !== e.r || pcomp_code !== e.p || low_pwr !== e.lp || soft_rst !== e.sr) begin
        n_bad++;
        $display("FAIL %s: got rate=%0d pc=%0d lp=%0b sr=%0b exp rate=%0d pc=%0d lp=%0b sr=%0b",
          e.tag, rate_code, pcomp_code, low_pwr, soft_rst, e.r, e.p, e.lp, e.sr);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1 reset state");
    cyc(1, 0, 1, 8'h01, 0, 2'd0, 0, 0, "R2 write rate 1");
    idle("R2 rate 1 visible");
    cyc(1, 0, 1, 8'h1C, 0, 2'd0, 0, 0, "R5 write pcomp 7");
    cyc(0, 0, 0, 8'h00, 1, 2'd3, 0, 0, "R5 pcomp 7 visible");
    idle("R3 alt rate 3, R5 pcomp held");
    cyc(1, 0, 1, 8'h08, 0, 2'd0, 0, 0, "R3 own write after alt");
    idle("R3 own rate 0 wins");
    cyc(1, 0, 1, 8'h01, 1, 2'd2, 0, 0, "R4 same-cycle writes");
    idle("R4 alt rate has priority");
    cyc(0, 1, 1, 8'hFF, 0, 2'd0, 0, 0, "R11 host read");
    cyc(1, 0, 0, 8'hFF, 0, 2'd0, 0, 0, "R11 read left state");
    idle("R11 unselected write ignored");
    cyc(1, 0, 1, 8'h25, 0, 2'd0, 0, 0, "R11 reserved bit set");
    idle("R11 reserved bit ignored");
    cyc(1, 0, 1, 8'h45, 0, 2'd0, 0, 0, "R8 enter low power");
    idle("R8 low power on");
    cyc(0, 0, 0, 8'h00, 0, 2'd0, 0, 1, "R9 status access drops flag");
    idle("R9 stays low after status access");
    cyc(1, 0, 1, 8'h45, 0, 2'd0, 0, 0, "R8 enter again");
    idle("R8 low power held");
    cyc(0, 0, 0, 8'h00, 0, 2'd0, 1, 0, "R9 data access drops flag");
    cyc(1, 0, 1, 8'h45, 0, 2'd0, 0, 1, "R9 entry write wins over access");
    idle("R8 set despite same-cycle access");
    cyc(1, 0, 1, 8'hCA, 0, 2'd0, 0, 0, "R10 reset with low-power bit");
    idle("R6 pulse, R10 low power off, R7 fields kept");
    idle("R6 pulse cleared");
    cyc(1, 0, 1, 8'h8F, 0, 2'd0, 0, 0, "R6 second reset write");
    idle("R7 rate 3 pcomp 3 after reset");
    idle("R6 single cycle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule